// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block sits between a register-access client and a clause-22 MDIO command engine. It takes one 32-bit register request at a time (read, write or read-modify-write) and turns it into a short sequence of 16-bit management transactions aimed at an attached switch. Such a switch exposes its wide register space through a paging scheme: a page number is written first to a fixed management address, and the word is then moved through a pair of 16-bit data registers.

Each request begins with a page-select write. The bridge then waits a fixed settling time. It then transfers the low half-word followed by the high half-word. For a read-modify-write, both halves are read, merged with the request's mask and value, and written back. No second page write occurs. Driving the MDC/MDIO pins is left to a downstream shifter that consumes the command port one transaction at a time.

Top module: `mdio_paged_bridge`

## Requirements
- R1: After synchronous reset, req_ready is 1, while cmd_start and rsp_done are 0.
- R2: req_waddr is the byte address shifted right by two. The data register number r1 is {req_waddr[3:0],0}, so it is always even. The sub-address r2 is req_waddr[6:4]. The page is req_waddr[15:7].
- R3: Every request first issues a write command to PHY address 0x18, register 0, with the 9-bit page zero-extended as data.
- R4: The first data command of a request starts exactly SETTLE_CYCLES+1 cycles after the cycle in which the page write's cmd_done was high.
- R5: Data commands use PHY address 0x10 OR r2. The low half goes to register r1 and the high half to register r1+1, and the low half always comes first.
- R6: Op codes 0 and 3 are reads. rsp_rdata returns {high half, low half} in the single cycle when rsp_done is high.
- R7: Op code 1 is a write. It sends req_wdata[15:0] to r1 and then req_wdata[31:16] to r1+1, and rsp_rdata echoes the written word.
- R8: Op code 2 is a read-modify-write under one page write. It reads both halves, computes (old AND NOT req_mask) OR req_wdata, writes that value low half first, and returns it on rsp_rdata.
- R9: A read-modify-write with a zero mask sets the bits given in req_wdata. One with a zero value clears the bits given in req_mask.
- R10: A request is taken only while req_ready is high. req_ready drops in the cycle after acceptance and returns with rsp_done. Requests presented while busy are ignored.
- R11: cmd_start is a one-cycle pulse. The command fields stay stable until the matching cmd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request will be taken |
| req_op | input | 2 | 0/3 read, 1 write, 2 read-modify-write |
| req_waddr | input | 16 | Word address (byte address >> 2) |
| req_wdata | input | 32 | Write value / bits to OR in |
| req_mask | input | 32 | Bits to clear before OR (read-modify-write) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Result word, valid with rsp_done |
| cmd_start | output | 1 | Start pulse to the MDIO shifter |
| cmd_phy | output | 5 | PHY address of the command |
| cmd_reg | output | 5 | Register number of the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_wdata | output | 16 | Write half-word |
| cmd_done | input | 1 | Shifter finished the command |
| cmd_rdata | input | 16 | Read half-word, valid with cmd_done |

## Verification
The page command appears one cycle after acceptance. Each later command appears one cycle after the cmd_done of the previous one, except the first data command, which is due exactly SETTLE_CYCLES+1 cycles after the page write's done. The result pulse follows the last cmd_done by one cycle. The bench's shifter model samples on the falling edge and compares every command against a queue of expected commands built from the request. It stamps the page-done cycle so the settling gap can be compared exactly. A monitor checks each rsp_done pulse against the queued result, also on the falling edge.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_RSVD  = 2'd3
  } mpb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_SETTLE,
    ST_LO,
    ST_HI
  } mpb_state_e;

  localparam logic [4:0] PAGE_PHY_ADDR = 5'h18;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;
endpackage

// File: rtl/mpb_addr_split.sv
module mpb_addr_split #(
  parameter int WADDR_W = 16,
  parameter int REG_W   = 5,
  parameter int SUB_W   = 3,
  parameter int PAGE_W  = 9
) (
  input  logic [WADDR_W-1:0] waddr,
  output logic [REG_W-1:0]   reg_lo,
  output logic [SUB_W-1:0]   sub,
  output logic [PAGE_W-1:0]  page
);
  // word address bit k corresponds to byte address bit k+2
  localparam int REG_BITS = REG_W - 1;
  localparam int SUB_LSB  = REG_BITS;
  localparam int PAGE_LSB = SUB_LSB + SUB_W;

  assign reg_lo = {waddr[REG_BITS-1:0], 1'b0};
  assign sub    = waddr[SUB_LSB +: SUB_W];
  assign page   = waddr[PAGE_LSB +: PAGE_W];
endmodule

// File: rtl/mpb_settle_timer.sv
module mpb_settle_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  assign expired = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= LOAD;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  // R4
  timer_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> active);
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mpb_pkg::*;
#(
  parameter int WADDR_W       = 16,
  parameter int DATA_W        = 32,
  parameter int PHY_W         = 5,
  parameter int REG_W         = 5,
  parameter int SUB_W         = 3,
  parameter int PAGE_W        = 9,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [WADDR_W-1:0]    req_waddr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W-1:0]     req_mask,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  cmd_start,
  output logic [PHY_W-1:0]      cmd_phy,
  output logic [REG_W-1:0]      cmd_reg,
  output logic                  cmd_write,
  output logic [DATA_W/2-1:0]   cmd_wdata,
  input  logic                  cmd_done,
  input  logic [DATA_W/2-1:0]   cmd_rdata
);
  localparam int HALF_W = DATA_W / 2;

  mpb_state_e            state;
  mpb_op_e               op_q;
  logic                  wr_phase;
  logic [DATA_W-1:0]     word_q, wdata_q, mask_q;
  logic [REG_W-1:0]      rlo_q, split_reg;
  logic [SUB_W-1:0]      sub_q, split_sub;
  logic [PAGE_W-1:0]     split_page;
  logic [DATA_W-1:0]     rd_word, merged;
  logic                  settle_go, settle_exp;

  mpb_addr_split #(
    .WADDR_W(WADDR_W), .REG_W(REG_W), .SUB_W(SUB_W), .PAGE_W(PAGE_W)
  ) u_split (
    .waddr (req_waddr),
    .reg_lo(split_reg),
    .sub   (split_sub),
    .page  (split_page)
  );

  assign settle_go = (state == ST_PAGE) && cmd_done;

  mpb_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (settle_go),
    .expired(settle_exp)
  );

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    rd_word = {cmd_rdata, word_q[HALF_W-1:0]};
    merged  = (rd_word & ~mask_q) | wdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_READ;
      wr_phase  <= 1'b0;
      word_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      rlo_q     <= '0;
      sub_q     <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      cmd_start <= 1'b0;
      cmd_phy   <= '0;
      cmd_reg   <= '0;
      cmd_write <= 1'b0;
      cmd_wdata <= '0;
    end else begin
      cmd_start <= 1'b0;
      rsp_done  <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          op_q      <= mpb_op_e'(req_op);
          wdata_q   <= req_wdata;
          mask_q    <= req_mask;
          word_q    <= req_wdata;
          rlo_q     <= split_reg;
          sub_q     <= split_sub;
          wr_phase  <= (mpb_op_e'(req_op) == OP_WRITE);
          cmd_start <= 1'b1;
          cmd_phy   <= PAGE_PHY_ADDR;
          cmd_reg   <= '0;
          cmd_write <= 1'b1;
          cmd_wdata <= HALF_W'(split_page);
          state     <= ST_PAGE;
        end
        ST_PAGE: if (cmd_done) state <= ST_SETTLE;
        ST_SETTLE: if (settle_exp) begin
          cmd_start <= 1'b1;
          cmd_phy   <= DATA_PHY_BASE | PHY_W'(sub_q);
          cmd_reg   <= rlo_q;
          cmd_write <= wr_phase;
          cmd_wdata <= word_q[HALF_W-1:0];
          state     <= ST_LO;
        end
        ST_LO: if (cmd_done) begin
          if (!wr_phase) word_q[HALF_W-1:0] <= cmd_rdata;
          cmd_start <= 1'b1;
          cmd_reg   <= rlo_q | REG_W'(1);
          cmd_wdata <= word_q[DATA_W-1:HALF_W];
          state     <= ST_HI;
        end
        ST_HI: if (cmd_done) begin
          if (wr_phase) begin
            rsp_done  <= 1'b1;
            rsp_rdata <= word_q;
            state     <= ST_IDLE;
          end else if (op_q == OP_RMW) begin
            word_q    <= merged;
            wr_phase  <= 1'b1;
            cmd_start <= 1'b1;
            cmd_reg   <= rlo_q;
            cmd_write <= 1'b1;
            cmd_wdata <= merged[HALF_W-1:0];
            state     <= ST_LO;
          end else begin
            rsp_done  <= 1'b1;
            rsp_rdata <= rd_word;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_start |-> ($stable(cmd_phy) && $stable(cmd_reg) &&
                    $stable(cmd_write) && $stable(cmd_wdata)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && cmd_start));
  // R3
  page_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_phy == PAGE_PHY_ADDR) |-> (cmd_write && cmd_reg == '0));
  // R5
  odd_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_reg[0]) |-> (cmd_phy[PHY_W-1:SUB_W] == DATA_PHY_BASE[PHY_W-1:SUB_W]));
endmodule

// File: tb/mdio_paged_bridge_tb.sv
module mdio_paged_bridge_tb;
  localparam int SETTLE = 16;
  localparam int LAT    = 3;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic        wr;
    logic [15:0] wd;
  } cmd_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_waddr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_mask = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        cmd_start;
  logic [4:0]  cmd_phy;
  logic [4:0]  cmd_reg;
  logic        cmd_write;
  logic [15:0] cmd_wdata;
  logic        cmd_done = 1'b0;
  logic [15:0] cmd_rdata = '0;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  cmd_item_t   exp_cmd[$];
  string       exp_cmd_tag[$];
  logic [31:0] exp_rsp[$];
  string       exp_rsp_tag[$];
  logic [15:0] sw_mem [0:1023];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_paged_bridge #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_waddr(req_waddr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cmd_start(cmd_start), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shifter model and command scoreboard
  initial begin
    int page_done_cyc;
    bit after_page;
    cmd_item_t got, want;
    string tag;
    after_page = 1'b0;
    page_done_cyc = 0;
    forever begin
      @(negedge clk);
      if (cmd_done) cmd_done = 1'b0;
      if (!rst && cmd_start) begin
        got = '{phy: cmd_phy, rg: cmd_reg, wr: cmd_write, wd: cmd_wdata};
        if (after_page) begin
          chk(cyc - page_done_cyc == SETTLE + 1, "R4 settle gap",
              32'(cyc - page_done_cyc), 32'(SETTLE + 1));
          after_page = 1'b0;
        end
        if (exp_cmd.size() == 0) begin
          chk(1'b0, "R10 unexpected command", 32'(got), 32'h0);
        end else begin
          want = exp_cmd.pop_front();
          tag  = exp_cmd_tag.pop_front();
          if (!want.wr) begin
            got.wd  = '0;
            want.wd = '0;
          end
          chk(got == want, tag, 32'(got), 32'(want));
        end
        for (int k = 0; k < LAT; k++) @(negedge clk);
        chk(!cmd_start && cmd_phy == got.phy && cmd_reg == got.rg && cmd_write == got.wr,
            "R11 command held", {cmd_start, 16'h0, cmd_phy, cmd_reg, cmd_write, 4'h0},
            {1'b0, 16'h0, got.phy, got.rg, got.wr, 4'h0});
        if (got.wr) sw_mem[{got.phy, got.rg}] = cmd_wdata;
        else        cmd_rdata = sw_mem[{got.phy, got.rg}];
        cmd_done = 1'b1;
        if (got.phy == 5'h18) begin
          page_done_cyc = cyc;
          after_page = 1'b1;
        end
      end
    end
  end

  // response monitor
  initial begin
    logic [31:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (!rst && rsp_done) begin
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
        end else begin
          e = exp_rsp.pop_front();
          t = exp_rsp_tag.pop_front();
          chk(rsp_rdata == e, t, rsp_rdata, e);
          chk(req_ready, "R10 ready with done", 32'(req_ready), 32'd1);
        end
      end
    end
  end

  task automatic push_cmd(input logic [4:0] phy, input logic [4:0] rg, input logic wr,
                          input logic [15:0] wd, input string tag);
    exp_cmd.push_back('{phy: phy, rg: rg, wr: wr, wd: wd});
    exp_cmd_tag.push_back(tag);
  endtask

  task automatic do_req(input logic [1:0] op, input logic [15:0] wa, input logic [31:0] wd,
                        input logic [31:0] mk, input string dtag, input string rtag);
    logic [8:0]  pg;
    logic [4:0]  phy, r1;
    logic [31:0] old, nw;
    pg  = wa[15:7];
    phy = 5'h10 | {2'b00, wa[6:4]};
    r1  = {wa[3:0], 1'b0};
    old = {sw_mem[{phy, r1 | 5'd1}], sw_mem[{phy, r1}]};
    push_cmd(5'h18, 5'd0, 1'b1, {7'd0, pg}, "R2 R3 page write");
    if (op == 2'd1) begin
      push_cmd(phy, r1, 1'b1, wd[15:0], dtag);
      push_cmd(phy, r1 | 5'd1, 1'b1, wd[31:16], dtag);
      exp_rsp.push_back(wd);
    end else if (op == 2'd2) begin
      nw = (old & ~mk) | wd;
      push_cmd(phy, r1, 1'b0, 16'h0, dtag);
      push_cmd(phy, r1 | 5'd1, 1'b0, 16'h0, dtag);
      push_cmd(phy, r1, 1'b1, nw[15:0], dtag);
      push_cmd(phy, r1 | 5'd1, 1'b1, nw[31:16], dtag);
      exp_rsp.push_back(nw);
    end else begin
      push_cmd(phy, r1, 1'b0, 16'h0, dtag);
      push_cmd(phy, r1 | 5'd1, 1'b0, 16'h0, dtag);
      exp_rsp.push_back(old);
    end
    exp_rsp_tag.push_back(rtag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_waddr = wa; req_wdata = wd; req_mask = mk; req_valid = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10 busy after accept", 32'(req_ready), 32'd0);
    // a second request while busy must be ignored
    req_op = 2'd1; req_waddr = ~wa; req_wdata = ~wd;
    @(negedge clk);
    @(negedge clk);
    chk(!req_ready, "R10 still busy", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    while (exp_rsp.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11 watchdog expired", 32'(cyc), 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) sw_mem[i] = 16'(i * 40503) ^ 16'h3c5a;
    repeat (4) @(negedge clk);
    chk(req_ready && !cmd_start && !rsp_done, "R1 reset state",
        {29'd0, req_ready, cmd_start, rsp_done}, 32'd4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !cmd_start && !rsp_done, "R1 after release",
        {29'd0, req_ready, cmd_start, rsp_done}, 32'd4);

    do_req(2'd0, {9'h1a5, 3'h5, 4'hb}, 32'h0, 32'h0, "R2 R5 read order", "R6 read data");
    do_req(2'd1, {9'h1a5, 3'h5, 4'hb}, 32'hcafe_1234, 32'h0, "R5 R7 write halves", "R7 write echo");
    do_req(2'd0, {9'h1a5, 3'h5, 4'hb}, 32'h0, 32'h0, "R5 readback", "R7 R6 readback");
    do_req(2'd2, {9'h033, 3'h2, 4'h4}, 32'h0012_3000, 32'h00ff_f000, "R8 rmw sequence", "R8 rmw result");
    do_req(2'd2, {9'h100, 3'h7, 4'h0}, 32'h8000_0001, 32'h0, "R9 set bits sequence", "R9 set bits");
    do_req(2'd2, {9'h100, 3'h7, 4'h0}, 32'h0, 32'h0000_00f0, "R9 clear bits sequence", "R9 clear bits");
    do_req(2'd3, {9'h0ff, 3'h1, 4'h9}, 32'h0, 32'h0, "R6 op3 read", "R6 op3 data");
    do_req(2'd1, 16'h0000, 32'h0bad_f00d, 32'h0, "R2 R7 zero address", "R7 zero address echo");
    do_req(2'd0, 16'h0000, 32'h0, 32'h0, "R2 zero address read", "R6 zero address data");
    do_req(2'd0, 16'hffff, 32'h0, 32'h0, "R2 R5 top address", "R6 top address data");

    repeat (8) @(negedge clk);
    chk(exp_cmd.size() == 0, "R10 no missing commands", 32'(exp_cmd.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule